// File: doc/BRIEF.md
# Serial Flash Continuous Word-Program Controller

This block is the command side of a serial flash slave. It samples the serial clock, active-low chip select and serial data input with its own system clock. It decodes a small command set and shifts response bytes out on the serial output. The storage is a small byte array with an erased value of FF. A program operation can only clear bits, so it is an AND of the new data into the stored byte. A cycle counter stands in for the cell program time.

The main feature is a continuous word-program mode. The first program command carries a 3-byte address and two data bytes, which land in the word that address selects. Each later program command carries only the opcode and two data bytes, and they go to the next word up. While the mode is active only a short list of opcodes is accepted. The mode ends on a write-disable once programming has finished. It also ends by itself after the top word of the array is written, or when a write aims at the protected range. The serial output can be turned into a live ready/busy line for the duration of the mode.

A host sets the write-enable latch, issues the first program command with an address, and polls status or the ready/busy line. It then streams further two-byte bursts and finishes with a write-disable.

Top module: `cpflash_ctrl`

## Requirements
- R1: After reset the write-enable latch, the busy flag and the mode flag are 0, every array byte reads FF, and so_en is 0 while cs_n is high.
- R2: Opcode 06 sets the write-enable latch. A program command (AD) issued while the latch is 0 changes no byte and does not enter the mode.
- R3: The first AD command sends three address bytes (the low address bits come from the last one) and then data bytes, all MSB first. The first data byte is ANDed into the even byte of the addressed word and the second into the odd byte, whatever address bit 0 was. A normal read (03 plus three address bytes) shifts out stored bytes from that address upward.
- R4: If cs_n rises after fewer than two data bytes, nothing is programmed and the word address does not advance. Data bytes after the second are ignored.
- R5: A program operation holds the busy flag at 1 for exactly PROG_CYCLES clock cycles. The status read (05) returns a byte with the busy flag at bit 0, the write-enable latch at bit 1 and zeros elsewhere.
- R6: While the mode is active, an AD command carries no address and programs the word after the previous one. Entering the mode coincides with the start of a program operation.
- R7: While the mode is active, only AD, 04, 05 and 2B are acted on. Any other opcode is ignored and shifts out zeros. An AD command issued while busy is ignored.
- R8: Opcode 04 clears the write-enable latch and leaves the mode only when the busy flag is 0. While busy it is ignored. The mode is active only while the write-enable latch is set.
- R9: The security read (2B) returns a byte whose bit 4 is the mode flag, with zeros elsewhere.
- R10: The address does not wrap. When the program of the top word of the array finishes, the mode flag and the write-enable latch clear.
- R11: Opcode OP_RB_ON, issued outside the mode and while idle, makes so show ready (1) or busy (0) whenever the mode is active and cs_n is low. OP_RB_OFF returns so to shifted data. Both opcodes are ignored while the mode is active. so_en follows cs_n being low.
- R12: A program command aimed at a word that overlaps the byte range PROT_LO..PROT_HI leaves the array unchanged, starts no busy period, clears the write-enable latch and ends the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; data sampled on rise, shifted out on fall |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, MSB first |
| so | output | 1 | Serial data out, or ready/busy in that mode |
| so_en | output | 1 | Output enable for so (tri-state control) |

## Verification
Directed sequences cover several cases: a program with the latch clear, a one-byte burst, a three-byte burst, an odd start address, an AD issued while busy, a write-disable issued while busy, the top word, and the protected range at entry and mid-stream. Each one separates a correct accept/ignore decision from a wrong one by reading the array and the status bytes afterwards. Seeded random bursts follow. Each has a random start word, a random bit 0 of the address and random data, and some carry a stray one-byte burst or a third byte. They run over words that earlier steps already programmed, so an overwrite instead of an AND, a wrong auto-increment, or an advance on a short burst each show up as a byte mismatch against the bench model.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADR,
    PH_DAT,
    PH_OUT,
    PH_IGN
  } phase_t;

  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_WDIS = 8'h04;
  localparam logic [7:0] OP_STAT = 8'h05;
  localparam logic [7:0] OP_SECR = 8'h2B;
  localparam logic [7:0] OP_CONT = 8'hAD;
  localparam logic [7:0] OP_READ = 8'h03;

  function automatic logic [7:0] status_byte(input logic wel, input logic wip);
    return {6'b000000, wel, wip};
  endfunction

  function automatic logic [7:0] secur_byte(input logic cp);
    return {3'b000, cp, 4'b0000};
  endfunction

  function automatic logic legal_in_cp(input logic [7:0] op);
    return (op == OP_CONT) || (op == OP_WDIS) || (op == OP_STAT) || (op == OP_SECR);
  endfunction

endpackage

// File: rtl/cpf_spi_port.sv
module cpf_spi_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       si,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       cs_fall,
  output logic       cs_rise,
  output logic       so_bit
);

  logic [SYNC_STAGES-1:0] sclk_sync, cs_sync, si_sync;
  logic                   sclk_d, cs_d;
  logic [2:0]             bit_q, bit_n;
  logic [6:0]             rx_q, rx_n;
  logic [7:0]             tx_q, tx_n;
  logic                   sclk_s, cs_s, si_s, sel, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      cs_sync   <= '1;
      si_sync   <= '0;
      sclk_d    <= 1'b0;
      cs_d      <= 1'b1;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], sclk};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      si_sync   <= {si_sync[SYNC_STAGES-2:0], si};
      sclk_d    <= sclk_s;
      cs_d      <= cs_s;
    end
  end

  assign sclk_s  = sclk_sync[SYNC_STAGES-1];
  assign cs_s    = cs_sync[SYNC_STAGES-1];
  assign si_s    = si_sync[SYNC_STAGES-1];
  assign sel     = ~cs_s;
  assign rise    = sel & sclk_s & ~sclk_d;
  assign fall    = sel & ~sclk_s & sclk_d;
  assign cs_fall = ~cs_s & cs_d;
  assign cs_rise = cs_s & ~cs_d;

  assign byte_done = rise && (bit_q == 3'd7);
  assign rx_byte   = {rx_q, si_s};
  assign so_bit    = tx_q[7];

  always_comb begin
    bit_n = bit_q;
    rx_n  = rx_q;
    tx_n  = tx_q;
    if (cs_fall) begin
      bit_n = 3'd0;
      tx_n  = 8'h00;
    end else if (rise) begin
      bit_n = bit_q + 3'd1;
      rx_n  = {rx_q[5:0], si_s};
      if (bit_q == 3'd7) tx_n = tx_byte;
    end else if (fall && (bit_q != 3'd0)) begin
      tx_n = {tx_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 3'd0;
      rx_q  <= 7'd0;
      tx_q  <= 8'h00;
    end else begin
      bit_q <= bit_n;
      rx_q  <= rx_n;
      tx_q  <= tx_n;
    end
  end

endmodule

// File: rtl/cpf_prog_timer.sv
module cpf_prog_timer #(
  parameter int CYCLES = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q, cnt_n;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

  always_comb begin
    cnt_n = cnt_q;
    if (start)     cnt_n = LOAD;
    else if (busy) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

endmodule

// File: rtl/cpf_cell_array.sv
module cpf_cell_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [ADDR_W-2:0] prog_wa,
  input  logic [7:0]        d_even,
  input  logic [7:0]        d_odd,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);

  localparam int WA_W  = ADDR_W - 1;
  localparam int WORDS = 1 << WA_W;

  logic [7:0] mem_ev [WORDS];
  logic [7:0] mem_od [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = prog_en && (prog_wa == WA_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_ev[w] <= 8'hFF;
        mem_od[w] <= 8'hFF;
      end else if (hit) begin
        mem_ev[w] <= mem_ev[w] & d_even;
        mem_od[w] <= mem_od[w] & d_odd;
      end
    end
  end

  assign rd_data = rd_addr[0] ? mem_od[rd_addr[ADDR_W-1:1]] : mem_ev[rd_addr[ADDR_W-1:1]];

endmodule

// File: rtl/cpf_cmd_ctrl.sv
module cpf_cmd_ctrl
  import cpf_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          PROT_LO   = 224,
  parameter int          PROT_HI   = 239,
  parameter logic [7:0]  OP_RB_ON  = 8'h70,
  parameter logic [7:0]  OP_RB_OFF = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic [7:0]        rx_byte,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              busy,
  input  logic              done,
  input  logic [7:0]        rd_data,
  output logic [7:0]        tx_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              prog_en,
  output logic [ADDR_W-2:0] prog_wa,
  output logic [7:0]        d_even,
  output logic [7:0]        d_odd,
  output logic              wel,
  output logic              cp_mode,
  output logic              rb_en
);

  localparam int WA_W = ADDR_W - 1;
  localparam logic [ADDR_W-1:0] P_LO = ADDR_W'(PROT_LO);
  localparam logic [ADDR_W-1:0] P_HI = ADDR_W'(PROT_HI);

  phase_t            ph_q, ph_n;
  logic [7:0]        cmd_q, cmd_n;
  logic [1:0]        idx_q, idx_n;
  logic [1:0]        nd_q, nd_n;
  logic [7:0]        d0_q, d0_n, d1_q, d1_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [ADDR_W-1:0] rp_q, rp_n;
  logic              wel_q, wel_n, cp_q, cp_n, rb_q, rb_n, last_q, last_n;
  logic [WA_W-1:0]   nwa_q, nwa_n, sel_wa;
  logic [ADDR_W+7:0] a_wide;
  logic [ADDR_W-1:0] a_new;
  logic              sel_prot;

  function automatic logic word_protected(input logic [WA_W-1:0] wa);
    logic [ADDR_W-1:0] lo_b, hi_b;
    lo_b = {wa, 1'b0};
    hi_b = {wa, 1'b1};
    return (hi_b >= P_LO) && (lo_b <= P_HI);
  endfunction

  assign a_wide   = {addr_q, rx_byte};
  assign a_new    = a_wide[ADDR_W-1:0];
  assign sel_wa   = cp_q ? nwa_q : addr_q[ADDR_W-1:1];
  assign sel_prot = word_protected(sel_wa);

  assign prog_wa = sel_wa;
  assign d_even  = d0_q;
  assign d_odd   = d1_q;
  assign wel     = wel_q;
  assign cp_mode = cp_q;
  assign rb_en   = rb_q;

  // response byte to load when the current byte completes
  always_comb begin
    tx_byte = 8'h00;
    rd_addr = rp_q + ADDR_W'(1);
    unique case (ph_q)
      PH_OPC: begin
        if (rx_byte == OP_STAT)      tx_byte = status_byte(wel_q, busy);
        else if (rx_byte == OP_SECR) tx_byte = secur_byte(cp_q);
      end
      PH_ADR: begin
        rd_addr = a_new;
        if ((cmd_q == OP_READ) && (idx_q == 2'd2)) tx_byte = rd_data;
      end
      PH_OUT: begin
        if (cmd_q == OP_STAT)      tx_byte = status_byte(wel_q, busy);
        else if (cmd_q == OP_SECR) tx_byte = secur_byte(cp_q);
        else if (cmd_q == OP_READ) tx_byte = rd_data;
      end
      default: tx_byte = 8'h00;
    endcase
  end

  always_comb begin
    ph_n    = ph_q;
    cmd_n   = cmd_q;
    idx_n   = idx_q;
    nd_n    = nd_q;
    d0_n    = d0_q;
    d1_n    = d1_q;
    addr_n  = addr_q;
    rp_n    = rp_q;
    wel_n   = wel_q;
    cp_n    = cp_q;
    rb_n    = rb_q;
    nwa_n   = nwa_q;
    last_n  = last_q;
    prog_en = 1'b0;

    if (cs_fall) begin
      ph_n  = PH_OPC;
      cmd_n = 8'h00;
      idx_n = 2'd0;
      nd_n  = 2'd0;
    end else if (byte_done) begin
      unique case (ph_q)
        PH_OPC: begin
          idx_n = 2'd0;
          if (cp_q && !legal_in_cp(rx_byte)) begin
            ph_n  = PH_IGN;
            cmd_n = 8'h00;
          end else begin
            cmd_n = rx_byte;
            if (rx_byte == OP_CONT)                             ph_n = cp_q ? PH_DAT : PH_ADR;
            else if (rx_byte == OP_READ)                        ph_n = PH_ADR;
            else if ((rx_byte == OP_STAT) || (rx_byte == OP_SECR)) ph_n = PH_OUT;
            else                                                ph_n = PH_IGN;
          end
        end
        PH_ADR: begin
          addr_n = a_new;
          idx_n  = idx_q + 2'd1;
          if (idx_q == 2'd2) begin
            ph_n = (cmd_q == OP_READ) ? PH_OUT : PH_DAT;
            rp_n = a_new;
          end
        end
        PH_DAT: begin
          if (nd_q == 2'd0)      d0_n = rx_byte;
          else if (nd_q == 2'd1) d1_n = rx_byte;
          if (nd_q != 2'd2) nd_n = nd_q + 2'd1;
        end
        PH_OUT: begin
          if (cmd_q == OP_READ) rp_n = rp_q + ADDR_W'(1);
        end
        default: ph_n = ph_q;
      endcase
    end else if (cs_rise) begin
      if (cmd_q == OP_WEN) begin
        if (!cp_q && !busy) wel_n = 1'b1;
      end else if (cmd_q == OP_WDIS) begin
        if (!busy) begin
          wel_n = 1'b0;
          cp_n  = 1'b0;
        end
      end else if (cmd_q == OP_RB_ON) begin
        if (!cp_q && !busy) rb_n = 1'b1;
      end else if (cmd_q == OP_RB_OFF) begin
        if (!cp_q && !busy) rb_n = 1'b0;
      end else if (cmd_q == OP_CONT) begin
        if ((ph_q == PH_DAT) && (nd_q == 2'd2) && wel_q && !busy) begin
          if (sel_prot) begin
            wel_n = 1'b0;
            cp_n  = 1'b0;
          end else begin
            prog_en = 1'b1;
            cp_n    = 1'b1;
            nwa_n   = sel_wa + WA_W'(1);
            last_n  = &sel_wa;
          end
        end
      end
    end

    if (done && last_q) begin
      wel_n  = 1'b0;
      cp_n   = 1'b0;
      last_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_OPC;
      cmd_q  <= 8'h00;
      idx_q  <= 2'd0;
      nd_q   <= 2'd0;
      d0_q   <= 8'hFF;
      d1_q   <= 8'hFF;
      addr_q <= '0;
      rp_q   <= '0;
      wel_q  <= 1'b0;
      cp_q   <= 1'b0;
      rb_q   <= 1'b0;
      nwa_q  <= '0;
      last_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      cmd_q  <= cmd_n;
      idx_q  <= idx_n;
      nd_q   <= nd_n;
      d0_q   <= d0_n;
      d1_q   <= d1_n;
      addr_q <= addr_n;
      rp_q   <= rp_n;
      wel_q  <= wel_n;
      cp_q   <= cp_n;
      rb_q   <= rb_n;
      nwa_q  <= nwa_n;
      last_q <= last_n;
    end
  end

endmodule

// File: rtl/cpflash_ctrl.sv
module cpflash_ctrl #(
  parameter int         ADDR_W      = 8,
  parameter int         PROG_CYCLES = 600,
  parameter int         PROT_LO     = 224,
  parameter int         PROT_HI     = 239,
  parameter logic [7:0] OP_RB_ON    = 8'h70,
  parameter logic [7:0] OP_RB_OFF   = 8'h80,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic si,
  output logic so,
  output logic so_en
);

  logic              byte_done, cs_fall, cs_rise, so_bit;
  logic [7:0]        rx_byte, tx_byte, rd_data, d_even, d_odd;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-2:0] prog_wa;
  logic              prog_en, busy, done, wel, cp_mode, rb_en;

  cpf_spi_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .tx_byte(tx_byte), .byte_done(byte_done), .rx_byte(rx_byte),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .so_bit(so_bit)
  );

  cpf_cmd_ctrl #(
    .ADDR_W(ADDR_W), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI),
    .OP_RB_ON(OP_RB_ON), .OP_RB_OFF(OP_RB_OFF)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .busy(busy), .done(done),
    .rd_data(rd_data), .tx_byte(tx_byte), .rd_addr(rd_addr),
    .prog_en(prog_en), .prog_wa(prog_wa), .d_even(d_even), .d_odd(d_odd),
    .wel(wel), .cp_mode(cp_mode), .rb_en(rb_en)
  );

  cpf_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_en), .busy(busy), .done(done)
  );

  cpf_cell_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_wa(prog_wa),
    .d_even(d_even), .d_odd(d_odd), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign so_en = ~cs_n;
  assign so    = so_en & ((cp_mode & rb_en) ? ~busy : so_bit);

endmodule

// File: rtl/cpflash_ctrl_chk.sv
module cpflash_ctrl_chk #(
  parameter int PROG_CYCLES = 600
) (
  input logic clk,
  input logic rst_n,
  input logic wel,
  input logic wip,
  input logic cp_mode,
  input logic rb_en,
  input logic prog_start
);

  localparam int CW = $clog2(PROG_CYCLES + 2);
  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   hi_cnt <= '0;
    else if (wip) hi_cnt <= hi_cnt + CW'(1);
    else          hi_cnt <= '0;
  end

  // R5
  wip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> (hi_cnt == CW'(PROG_CYCLES)));

  // R5
  wip_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> wel);

  // R8
  cp_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_mode |-> wel);

  // R7
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !wip);

  // R6
  cp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cp_mode) |-> wip);

  // R11
  rb_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_mode && $past(cp_mode)) |-> $stable(rb_en));

endmodule

bind cpflash_ctrl cpflash_ctrl_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wel(wel), .wip(busy), .cp_mode(cp_mode),
  .rb_en(rb_en), .prog_start(prog_en)
);

// File: tb/tb_cpflash_ctrl.sv
module tb_cpflash_ctrl;

  localparam int ADDR_W = 8;
  localparam int PROG   = 600;
  localparam int HALF   = 6;

  logic clk, rst_n, sclk, cs_n, si;
  logic so, so_en;
  int   checks, failures;
  logic [7:0] mdl [256];

  cpflash_ctrl #(
    .ADDR_W(ADDR_W), .PROG_CYCLES(PROG), .PROT_LO(224), .PROT_HI(239),
    .OP_RB_ON(8'h70), .OP_RB_OFF(8'h80), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
    .so(so), .so_en(so_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] exp_stat(input logic wel, input logic wip);
    return {6'b0, wel, wip};
  endfunction

  function automatic logic [7:0] exp_sec(input logic cp);
    return {3'b0, cp, 4'b0};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    ticks(HALF);
  endtask

  task automatic cs_high();
    ticks(HALF);
    cs_n = 1'b1;
    ticks(2 * HALF);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      si = b[i];
      ticks(HALF);
      r[i] = so;
      sclk = 1'b1;
      ticks(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_low();
    xfer(op, r);
    cs_high();
  endtask

  task automatic rd_stat(output logic [7:0] s);
    logic [7:0] r;
    cs_low();
    xfer(8'h05, r);
    xfer(8'h00, s);
    cs_high();
  endtask

  task automatic rd_sec(output logic [7:0] s);
    logic [7:0] r;
    cs_low();
    xfer(8'h2B, r);
    xfer(8'h00, s);
    cs_high();
  endtask

  task automatic rd_byte(input logic [7:0] a, output logic [7:0] d);
    logic [7:0] r;
    cs_low();
    xfer(8'h03, r);
    xfer(8'h00, r);
    xfer(8'h00, r);
    xfer(a, r);
    xfer(8'h00, d);
    cs_high();
  endtask

  task automatic cp_send(input bit with_addr, input logic [7:0] a, input int n,
                         input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic [7:0] r;
    cs_low();
    xfer(8'hAD, r);
    if (with_addr) begin
      xfer(8'h00, r);
      xfer(8'h00, r);
      xfer(a, r);
    end
    if (n > 0) xfer(d0, r);
    if (n > 1) xfer(d1, r);
    if (n > 2) xfer(d2, r);
    cs_high();
  endtask

  task automatic mprog(input logic [6:0] wa, input logic [7:0] d0, input logic [7:0] d1);
    mdl[{wa, 1'b0}] = mdl[{wa, 1'b0}] & d0;
    mdl[{wa, 1'b1}] = mdl[{wa, 1'b1}] & d1;
  endtask

  task automatic chk_mem(input string req, input logic [7:0] a);
    logic [7:0] d;
    rd_byte(a, d);
    chk(req, d, mdl[a]);
  endtask

  task automatic wait_prog();
    ticks(PROG + 20);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] s;
    logic [7:0] d;
    checks = 0;
    failures = 0;
    for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
    void'($urandom(32'd20240517));
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; si = 1'b0;
    ticks(5);
    rst_n = 1'b1;
    ticks(5);

    // R1 reset state
    chk("R1 so_en idle", {7'b0, so_en}, 8'h00);
    rd_stat(s);  chk("R1 status", s, exp_stat(0, 0));
    rd_sec(s);   chk("R1 security", s, exp_sec(0));
    chk_mem("R1 erased", 8'h00);
    chk_mem("R1 erased top", 8'hFF);

    // R2 program without write enable
    cp_send(1, 8'h10, 2, 8'h00, 8'h00, 8'h00);
    rd_sec(s);   chk("R2 no mode", s, exp_sec(0));
    chk_mem("R2 unchanged", 8'h10);
    cmd1(8'h06);
    rd_stat(s);  chk("R2 wel set", s, exp_stat(1, 0));

    // R4 one data byte only
    cp_send(1, 8'h20, 1, 8'h00, 8'h00, 8'h00);
    rd_sec(s);   chk("R4 short no mode", s, exp_sec(0));
    rd_stat(s);  chk("R4 short no busy", s, exp_stat(1, 0));
    chk_mem("R4 short unchanged", 8'h20);

    // R3 odd start address, third byte ignored (R4), R5 busy
    cp_send(1, 8'h31, 3, 8'hA5, 8'h3C, 8'h00);
    mprog(7'h18, 8'hA5, 8'h3C);
    rd_stat(s);  chk("R5 busy status", s, exp_stat(1, 1));
    rd_sec(s);   chk("R9 mode bit", s, exp_sec(1));
    wait_prog();
    rd_stat(s);  chk("R5 idle status", s, exp_stat(1, 0));
    // R6 auto increment
    cp_send(0, 8'h00, 2, 8'h0F, 8'hF0, 8'h00);
    mprog(7'h19, 8'h0F, 8'hF0);
    wait_prog();
    cp_send(0, 8'h00, 1, 8'h00, 8'h00, 8'h00);
    cp_send(0, 8'h00, 2, 8'h55, 8'hAA, 8'h00);
    mprog(7'h1A, 8'h55, 8'hAA);
    wait_prog();
    cmd1(8'h04);
    rd_sec(s);   chk("R8 exit mode", s, exp_sec(0));
    chk_mem("R3 even byte", 8'h30);
    chk_mem("R3 odd byte", 8'h31);
    chk_mem("R6 next word even", 8'h32);
    chk_mem("R6 next word odd", 8'h33);
    chk_mem("R4 short burst no advance", 8'h34);
    chk_mem("R4 short burst no advance", 8'h35);
    cmd1(8'h06);
    cp_send(1, 8'h30, 2, 8'h0F, 8'hFF, 8'h00);
    mprog(7'h18, 8'h0F, 8'hFF);
    wait_prog();
    cmd1(8'h04);
    chk_mem("R3 and program", 8'h30);

    // R7 busy AD ignored, R8 disable while busy ignored
    cmd1(8'h06);
    cp_send(1, 8'h40, 2, 8'h11, 8'h22, 8'h00);
    mprog(7'h20, 8'h11, 8'h22);
    cp_send(0, 8'h00, 2, 8'h33, 8'h44, 8'h00);
    cmd1(8'h04);
    wait_prog();
    rd_sec(s);   chk("R8 disable while busy", s, exp_sec(1));
    rd_byte(8'h40, d);
    chk("R7 read ignored in mode", d, 8'h00);
    cmd1(8'h70);
    cs_n = 1'b0;
    ticks(HALF);
    chk("R7 rb enable ignored in mode", {7'b0, so}, 8'h00);
    cs_high();
    cp_send(0, 8'h00, 2, 8'h55, 8'h66, 8'h00);
    mprog(7'h21, 8'h55, 8'h66);
    wait_prog();
    cmd1(8'h04);
    rd_sec(s);   chk("R8 mode cleared", s, exp_sec(0));
    rd_stat(s);  chk("R8 wel cleared", s, exp_stat(0, 0));
    chk_mem("R7 first word", 8'h40);
    chk_mem("R7 busy burst dropped", 8'h42);
    chk_mem("R7 busy burst dropped", 8'h43);

    // R11 ready/busy on so
    cmd1(8'h70);
    cmd1(8'h06);
    cp_send(1, 8'h50, 2, 8'h77, 8'h88, 8'h00);
    mprog(7'h28, 8'h77, 8'h88);
    cs_n = 1'b0;
    ticks(HALF);
    chk("R11 busy level", {6'b0, so_en, so}, 8'h02);
    wait_prog();
    chk("R11 ready level", {6'b0, so_en, so}, 8'h03);
    cs_n = 1'b1;
    ticks(HALF);
    chk("R11 tristate", {7'b0, so_en}, 8'h00);
    cmd1(8'h80);
    cs_n = 1'b0;
    ticks(HALF);
    chk("R11 disable ignored in mode", {7'b0, so}, 8'h01);
    cs_high();
    cmd1(8'h04);
    cmd1(8'h80);
    rd_stat(s);  chk("R11 normal status back", s, exp_stat(0, 0));
    chk_mem("R11 programmed", 8'h51);

    // R10 top word, no wrap
    cmd1(8'h06);
    cp_send(1, 8'hFE, 2, 8'h12, 8'h34, 8'h00);
    mprog(7'h7F, 8'h12, 8'h34);
    rd_sec(s);   chk("R10 mode during top", s, exp_sec(1));
    wait_prog();
    rd_sec(s);   chk("R10 mode ends", s, exp_sec(0));
    rd_stat(s);  chk("R10 wel ends", s, exp_stat(0, 0));
    chk_mem("R10 top even", 8'hFE);
    chk_mem("R10 top odd", 8'hFF);
    chk_mem("R10 no wrap", 8'h00);

    // R12 protected range
    cmd1(8'h06);
    cp_send(1, 8'hE4, 2, 8'h00, 8'h00, 8'h00);
    rd_stat(s);  chk("R12 no busy wel clear", s, exp_stat(0, 0));
    rd_sec(s);   chk("R12 no mode", s, exp_sec(0));
    chk_mem("R12 unchanged", 8'hE4);
    cmd1(8'h06);
    cp_send(1, 8'hDE, 2, 8'hC3, 8'h3C, 8'h00);
    mprog(7'h6F, 8'hC3, 8'h3C);
    wait_prog();
    cp_send(0, 8'h00, 2, 8'h00, 8'h00, 8'h00);
    rd_stat(s);  chk("R12 mid-stream wel clear", s, exp_stat(0, 0));
    rd_sec(s);   chk("R12 mid-stream exit", s, exp_sec(0));
    chk_mem("R12 mid-stream unchanged", 8'hE0);
    chk_mem("R12 last good word", 8'hDF);

    // random bursts: R3 R4 R6
    for (int it = 0; it < 12; it++) begin
      logic [6:0] sw;
      int k;
      logic [7:0] a0, b0, b1;
      sw = 7'($urandom_range(0, 95));
      k  = $urandom_range(1, 3);
      a0 = 8'($urandom_range(0, 1));
      b0 = 8'($urandom);
      b1 = 8'($urandom);
      cmd1(8'h06);
      cp_send(1, {sw, a0[0]}, (it % 4 == 0) ? 3 : 2, b0, b1, 8'h00);
      mprog(sw, b0, b1);
      wait_prog();
      if (it % 3 == 1) cp_send(0, 8'h00, 1, 8'h00, 8'h00, 8'h00);
      for (int j = 1; j < k; j++) begin
        b0 = 8'($urandom);
        b1 = 8'($urandom);
        cp_send(0, 8'h00, 2, b0, b1, 8'h00);
        mprog(sw + 7'(j), b0, b1);
        wait_prog();
      end
      cmd1(8'h04);
      for (int j = 0; j < k; j++) begin
        chk_mem("R6 random even", {sw + 7'(j), 1'b0});
        chk_mem("R3 random odd", {sw + 7'(j), 1'b1});
      end
    end

    finish_run();
  end

endmodule